// File: doc/BRIEF.md
# I2C Responding-Address Scanner

This block discovers the 7-bit bus address of a single device whose address is not known in advance. It needs no start command: once reset is released, it hands an external I2C master one trial read request for each candidate address, in ascending order. The first candidate is 1, because address 0 is the general-call address. The master runs the bus transfer and reports whether the target acknowledged. The scanner moves to the next candidate on a not-acknowledge. It stops on the first acknowledge and keeps that address.

Once the scan has ended, the block raises one of two sticky flags. The found flag comes with the acknowledged address on a 7-bit output. The not-found flag means that every candidate up to 0x7F went unanswered. The count never wraps around. Either result holds until the next reset. After that point the block issues no more requests and takes no notice of the master. A typical use is locating a configuration EEPROM on a memory module, which normally answers at 0x50, before reading it.

The handshake with the master works as follows. For each candidate, `probe_req` is high for exactly one cycle while `probe_addr` carries the candidate. The master must then raise `probe_busy` for at least one cycle. A result counts only in a cycle where `probe_busy` is low and `probe_rsp_valid` is high. `probe_ack` is sampled in that same cycle: 1 means acknowledge, 0 means not-acknowledge.

Top module: `i2c_addr_scanner`

## Requirements
- R1: While reset is applied, `scan_found`, `scan_missing` and `found_addr` are all 0. After reset, the first request carries address 1, and address 0 is never requested.
- R2: Each request is a `probe_req` pulse of exactly one cycle. The next request does not come until the previous trial has returned a result.
- R3: After a not-acknowledge on candidate A, where A is below 0x7F, the next request carries address A+1.
- R4: A result is taken only in a cycle where `probe_busy` is 0 and `probe_rsp_valid` is 1. A `probe_rsp_valid` pulse while `probe_busy` is 1 is ignored, even when `probe_ack` is 1.
- R5: On an acknowledge, `scan_found` goes to 1 on the next clock edge. `found_addr` then shows the acknowledged address. Both hold until reset, and no further request is issued.
- R6: Once the scan has ended, master responses of any value on `probe_busy`, `probe_rsp_valid` and `probe_ack` leave `scan_found`, `scan_missing` and `found_addr` unchanged and produce no request.
- R7: A not-acknowledge on address 0x7F sets `scan_missing`. It stays set until reset, `found_addr` stays 0, and the candidate does not wrap to a new request.
- R8: `scan_found` and `scan_missing` are never 1 at the same time. An acknowledge on 0x7F sets `scan_found` with `found_addr` = 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| probe_req | output | 1 | One-cycle request for a trial read to `probe_addr` |
| probe_addr | output | 7 | Current candidate address |
| probe_busy | input | 1 | Master is working on a trial |
| probe_rsp_valid | input | 1 | Master result strobe; only counts while `probe_busy` is 0 |
| probe_ack | input | 1 | 1 = target acknowledged, 0 = not-acknowledge |
| scan_found | output | 1 | Sticky: a device answered |
| scan_missing | output | 1 | Sticky: no address from 1 to 0x7F answered |
| found_addr | output | 7 | Acknowledged address, 0 until found |

## Verification
The bench targets four corner cases. The first is a target at 0x04, where a design that started at 0 or skipped a step would show the wrong first address or the wrong probe count. The second is a target at 0x50, with an acknowledge strobe glitched in while the master is still busy. A design that sampled results during busy would stop at address 1. The third is a bus where nothing answers, and the fourth is a target at 0x7F. Together they separate a design that wraps around, or that raises the wrong flag at the last address, from a correct one. Stray responses after the scan has ended check that a design which still listens would move `found_addr` or issue a new request.

// File: rtl/scan_pkg.sv
// Package: shared types for the address scanner.
// Assumes: the probe sequencer is the only user of the state type.
package scan_pkg;

    typedef enum logic [2:0] {
        ST_LAUNCH,
        ST_ISSUE,
        ST_WAIT_BUSY,
        ST_WAIT_RESULT,
        ST_FOUND,
        ST_EXHAUSTED
    } scan_state_t;

endpackage

// File: rtl/scan_candidate.sv
// Candidate address register: holds the address under trial and steps it by
// one when told to.
// Assumes: 'advance' is never raised while at_last is set (the sequencer
// stops there instead).
module scan_candidate #(
    parameter int ADDR_W     = 7,
    parameter int FIRST_ADDR = 1,
    parameter int LAST_ADDR  = (1 << ADDR_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [ADDR_W-1:0] cand,
    output logic              at_last
);

    localparam logic [ADDR_W-1:0] FIRST_V = ADDR_W'(FIRST_ADDR);
    localparam logic [ADDR_W-1:0] LAST_V  = ADDR_W'(LAST_ADDR);

    // Step the candidate on each not-acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       cand <= FIRST_V;
        else if (advance) cand <= cand + 1'b1;
    end

    // Flag the final address of the range.
    assign at_last = (cand == LAST_V);

    assert_reset_start_R1: assert property (@(posedge clk)
        !rst_n |=> cand == FIRST_V);

    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> cand == $past(cand) + 1'b1);

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        at_last |-> !advance);

endmodule

// File: rtl/scan_sequencer.sv
// Probe sequencer: issues one request per candidate and waits for busy to
// rise and then fall with a result before it decides what to do next.
// Assumes: the master raises busy at least one cycle after each request.
module scan_sequencer
    import scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rsp_valid,
    input  logic ack,
    input  logic at_last,
    output logic req,
    output logic advance,
    output logic hit,
    output logic miss_last
);

    scan_state_t state, nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LAUNCH;
        else        state <= nxt;
    end

    // Next-state and decision pulses.
    always_comb begin
        nxt       = state;
        advance   = 1'b0;
        hit       = 1'b0;
        miss_last = 1'b0;
        case (state)
            ST_LAUNCH:    nxt = ST_ISSUE;
            ST_ISSUE:     nxt = ST_WAIT_BUSY;
            ST_WAIT_BUSY: if (busy) nxt = ST_WAIT_RESULT;
            ST_WAIT_RESULT: begin
                if (!busy && rsp_valid) begin
                    if (ack) begin
                        hit = 1'b1;
                        nxt = ST_FOUND;
                    end else if (at_last) begin
                        miss_last = 1'b1;
                        nxt       = ST_EXHAUSTED;
                    end else begin
                        advance = 1'b1;
                        nxt     = ST_ISSUE;
                    end
                end
            end
            ST_FOUND:     nxt = ST_FOUND;
            ST_EXHAUSTED: nxt = ST_EXHAUSTED;
            default:      nxt = ST_LAUNCH;
        endcase
    end

    // Request strobe.
    assign req = (state == ST_ISSUE);

    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({advance, hit, miss_last}) <= 1);

endmodule

// File: rtl/scan_result.sv
// Result latch: records the outcome of the scan as sticky flags and keeps
// the acknowledged address.
// Assumes: hit and miss_last each pulse at most once per reset period.
module scan_result #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              miss_last,
    input  logic [ADDR_W-1:0] cand,
    output logic              found,
    output logic              missing,
    output logic [ADDR_W-1:0] addr_q
);

    // Latch the outcome and the address that answered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            found   <= 1'b0;
            missing <= 1'b0;
            addr_q  <= '0;
        end else if (!found && !missing) begin
            if (hit) begin
                found  <= 1'b1;
                addr_q <= cand;
            end
            if (miss_last) missing <= 1'b1;
        end
    end

    assert_found_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> found);

    assert_missing_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        missing |=> missing && addr_q == '0);

    assert_addr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (found || missing) |=> $stable(addr_q));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && missing));

endmodule

// File: rtl/i2c_addr_scanner.sv
// Top: scans 7-bit addresses upward from 1 through an external I2C master
// and reports the first one that acknowledges, or that none did.
// Assumes: one trial per request; the master's result is valid only while
// busy is low.
module i2c_addr_scanner #(
    parameter int ADDR_W     = 7,
    parameter int FIRST_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              probe_req,
    output logic [ADDR_W-1:0] probe_addr,
    input  logic              probe_busy,
    input  logic              probe_rsp_valid,
    input  logic              probe_ack,
    output logic              scan_found,
    output logic              scan_missing,
    output logic [ADDR_W-1:0] found_addr
);

    localparam int LAST_ADDR = (1 << ADDR_W) - 1;

    logic advance, hit, miss_last, at_last;
    logic [ADDR_W-1:0] cand;

    scan_candidate #(
        .ADDR_W(ADDR_W), .FIRST_ADDR(FIRST_ADDR), .LAST_ADDR(LAST_ADDR)
    ) u_cand (
        .clk(clk), .rst_n(rst_n), .advance(advance),
        .cand(cand), .at_last(at_last)
    );

    scan_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .busy(probe_busy),
        .rsp_valid(probe_rsp_valid), .ack(probe_ack), .at_last(at_last),
        .req(probe_req), .advance(advance), .hit(hit), .miss_last(miss_last)
    );

    scan_result #(.ADDR_W(ADDR_W)) u_res (
        .clk(clk), .rst_n(rst_n), .hit(hit), .miss_last(miss_last),
        .cand(cand), .found(scan_found), .missing(scan_missing),
        .addr_q(found_addr)
    );

    assign probe_addr = cand;

    assert_busy_no_decision_R4: assert property (@(posedge clk) disable iff (!rst_n)
        probe_busy |=> $stable(scan_found) && $stable(scan_missing));

    assert_quiet_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_found || scan_missing) |-> !probe_req);

    assert_never_general_call_R1: assert property (@(posedge clk) disable iff (!rst_n)
        probe_req |-> probe_addr != '0);

endmodule

// File: tb/i2c_addr_scanner_test.sv
module i2c_addr_scanner_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic probe_req, scan_found, scan_missing;
    logic [6:0] probe_addr, found_addr;
    logic busy_r, valid_r, ack_r, busy_s, valid_s, ack_s;
    logic probe_busy, probe_rsp_valid, probe_ack;

    assign probe_busy      = busy_r | busy_s;
    assign probe_rsp_valid = valid_r | valid_s;
    assign probe_ack       = ack_r | ack_s;

    int checks = 0;
    int fails  = 0;

    // Responder settings and observations.
    int tgt = 0;
    bit tgt_en = 0;
    bit glitch = 0;
    int bcyc = 1;
    int probe_cnt = 0;
    int first_addr = -1;
    int last_addr = -1;
    int seq_err = 0;
    int width_err = 0;

    always #2 clk = ~clk;

    i2c_addr_scanner uut (
        .clk(clk), .rst_n(rst_n), .probe_req(probe_req), .probe_addr(probe_addr),
        .probe_busy(probe_busy), .probe_rsp_valid(probe_rsp_valid),
        .probe_ack(probe_ack), .scan_found(scan_found),
        .scan_missing(scan_missing), .found_addr(found_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural master: answers each request with busy, then a result.
    initial begin
        logic [6:0] cur;
        busy_r = 0; valid_r = 0; ack_r = 0;
        forever begin
            @(negedge clk);
            if (rst_n && probe_req) begin
                probe_cnt++;
                if (probe_cnt == 1) first_addr = int'(probe_addr);
                else if (int'(probe_addr) != last_addr + 1) seq_err++;
                last_addr = int'(probe_addr);
                cur = probe_addr;
                @(negedge clk);
                if (probe_req) width_err++;
                busy_r = 1;
                for (int i = 0; i < bcyc; i++) begin
                    @(negedge clk);
                    if (glitch && i == 0) begin valid_r = 1; ack_r = 1; end
                    else begin valid_r = 0; ack_r = 0; end
                    if (probe_req) width_err++;
                end
                @(negedge clk);
                busy_r = 0; valid_r = 1;
                ack_r = tgt_en && (int'(cur) == tgt);
                @(posedge clk); #1;
                valid_r = 0; ack_r = 0;
            end
        end
    end

    // One full scan from reset with the given target and expectations.
    task automatic run_scan(input int t, input bit en, input bit gl, input int bc,
                            input bit exp_found, input int exp_addr,
                            input int exp_probes, input string tag);
        tgt = t; tgt_en = en; glitch = gl; bcyc = bc;
        rst_n = 0;
        repeat (3) @(negedge clk);
        probe_cnt = 0; first_addr = -1; last_addr = -1; seq_err = 0; width_err = 0;
        check(scan_found == 0, {"R1 reset found ", tag}, scan_found, 0);
        check(scan_missing == 0, {"R1 reset missing ", tag}, scan_missing, 0);
        check(found_addr == 0, {"R1 reset addr ", tag}, found_addr, 0);
        rst_n = 1;
        for (int w = 0; w < 4000 && !(scan_found || scan_missing); w++) @(negedge clk);
        check(first_addr == 1, {"R1 first address ", tag}, first_addr, 1);
        check(seq_err == 0, {"R3 sequential step ", tag}, seq_err, 0);
        check(width_err == 0, {"R2 single-cycle request ", tag}, width_err, 0);
        check(probe_cnt == exp_probes, {"R3 probe count ", tag}, probe_cnt, exp_probes);
        check(scan_found == exp_found, {"R5 found flag ", tag}, scan_found, exp_found);
        check(scan_missing == !exp_found, {"R7 missing flag ", tag}, scan_missing, !exp_found);
        check(int'(found_addr) == exp_addr, {"R5 found address ", tag}, found_addr, exp_addr);
        repeat (20) @(negedge clk);
        check(probe_cnt == exp_probes, {"R7 no request after end ", tag}, probe_cnt, exp_probes);
        check(scan_found == exp_found && scan_missing == !exp_found,
              {"R8 flags held ", tag}, {scan_found, scan_missing}, {exp_found, !exp_found});
    endtask

    // Stray master activity after the scan ended must change nothing.
    task automatic stray_after_end(input int exp_addr);
        int cnt0;
        cnt0 = probe_cnt;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            busy_s = i[0]; valid_s = 1; ack_s = i[1];
        end
        @(negedge clk);
        busy_s = 0; valid_s = 0; ack_s = 0;
        repeat (3) @(negedge clk);
        check(scan_found == 1, "R6 found kept after stray responses", scan_found, 1);
        check(scan_missing == 0, "R6 missing stays clear", scan_missing, 0);
        check(int'(found_addr) == exp_addr, "R6 address kept", found_addr, exp_addr);
        check(probe_cnt == cnt0, "R6 no request from stray responses", probe_cnt, cnt0);
    endtask

    initial begin
        busy_s = 0; valid_s = 0; ack_s = 0;
        run_scan(4, 1, 0, 1, 1, 4, 4, "target 0x04");
        run_scan(8'h50, 1, 1, 3, 1, 8'h50, 8'h50, "R4 target 0x50 with busy glitch");
        run_scan(0, 0, 0, 1, 0, 0, 127, "no target");
        run_scan(8'h7F, 1, 0, 2, 1, 8'h7F, 127, "target 0x7F");
        stray_after_end(8'h7F);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule